// File: doc/BRIEF.md
# Least-Used Interrupt Link Allocator

This block hands out shared interrupt links to devices as they are enumerated. Each allocation request names the device slot and which of its four interrupt pins is being routed. The block picks one of eight links and returns the link number. If that link has never been routed, the block also picks a legacy IRQ line for it and emits a single write that programs the link's routing register. The block keeps a use counter for each link and a usage count for each IRQ line, plus its own copy of the eight routing registers, so later allocations can spread load over both.

In normal mode the link with the fewest users wins. In fixed mode the link comes from a formula over slot and pin, which gives a mapping that outside firmware can predict. Before the first allocation, configuration commands can reserve IRQ lines so they are never chosen, or pre-load a usage count so the lines are chosen less often. The first accepted allocation closes that window for good.

The allocation request is a valid/ready stream. `alloc_ready` is high only while the allocator is idle. A requester keeps `alloc_valid` and its fields steady until it sees a cycle with both high, and the block accepts exactly one request in that cycle. While a search runs, `alloc_ready` is low and any request shown is not taken. The result side has no back-pressure: `done` and `route_we` are one-cycle pulses that the consumer must capture. The command port is a plain one-cycle strobe.

Top module: `pirq_allocator`

## Requirements
- R1: After reset, `alloc_ready` is 1 and `busy`, `done`, `route_we` and `cmd_err` are 0. All eight links start unrouted, with their routing value at the disabled code 8'h80. IRQ lines 0, 1, 2, 8 and 13 start unavailable. Every other line starts with a usage count of 0.
- R2: A request is accepted on a clock edge where `alloc_valid` and `alloc_ready` are both 1. From the next cycle, `busy` is 1 and `alloc_ready` is 0 until the cycle in which `done` pulses. No request is taken during that time.
- R3: Count the accepting edge as edge k. If the chosen link is already routed, `done` is a one-cycle pulse after edge k+8. If the chosen link is unrouted, the pulse comes after edge k+24 instead: 8 cycles scan the links, one per clock, and 16 more scan the IRQ lines.
- R4: With `fixed_mode` at 0, the chosen link is the one with the smallest use counter. A tie goes to the lowest index.
- R5: With `fixed_mode` at 1, the chosen link index is (4 + `slot` + `intpin` + 1) mod 8. The `intpin` field encodes 0=INTA, 1=INTB, 2=INTC, 3=INTD, and the pin number used in the formula is the field value plus one.
- R6: `link_num` is the chosen zero-based index plus one, so it runs from 1 to 8. Every allocation increments the chosen link's use counter.
- R7: When the chosen link is unrouted, the block picks the available IRQ line with the smallest usage count, with a tie going to the lowest line number. It then increments that line's count. Together with `done` it pulses `route_we`, with `route_link` equal to `link_num` and `route_irq` set to the line. A link that is already routed gets no further write.
- R8: IRQ lines 0, 1, 2, 8 and 13 are never chosen.
- R9: A reserve command (`cmd_op`=0) makes the named IRQ line unavailable, so it is never chosen.
- R10: A use command (`cmd_op`=1) increments the named line's usage count. A use command aimed at a reserved or masked line has no effect.
- R11: A command is obeyed only before the first accepted request. A command that arrives in or after the cycle of that request is ignored and sets `cmd_err`, which stays at 1 until reset.
- R12: If no IRQ line is available, `done` still pulses after edge k+24 with the link number, and `route_we` stays 0. The link stays unrouted, so a later allocation of that link runs the IRQ search again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Allocation request valid |
| alloc_ready | output | 1 | Allocator idle, request can be taken |
| slot | input | 5 | Device slot number |
| intpin | input | 2 | Device interrupt pin, 0=INTA .. 3=INTD |
| fixed_mode | input | 1 | 1 selects the formula mapping for this request |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_op | input | 1 | 0 = reserve line, 1 = use line |
| cmd_irq | input | 4 | IRQ line named by the command |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: allocation finished |
| link_num | output | 4 | Chosen link, 1..8, valid with `done` |
| route_we | output | 1 | One-cycle pulse: program the link's routing register |
| route_link | output | 4 | Link being programmed, 1..8 |
| route_irq | output | 4 | IRQ line written into the link |
| cmd_err | output | 1 | Sticky: a command arrived after lockout |

## Verification
Every result of an allocation comes out on the same edge. That edge is 8 cycles after acceptance when the link is already routed, or 24 cycles after when an IRQ search runs. The bench counts clock edges from the accepting edge and requires `done` to appear at exactly the count its model predicts, then reads `link_num`, `route_we`, `route_link` and `route_irq` in that cycle. It also checks `busy` one edge after acceptance. Command effects, and the lack of them, only show up in later IRQ choices, so each command is judged through the allocations that follow it, and `cmd_err` is read one edge after the strobe.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINK = 2'd1,
    ST_IRQ  = 2'd2
  } alloc_st_e;

  typedef enum logic {
    OP_RESERVE = 1'b0,
    OP_USE     = 1'b1
  } cmd_op_e;

  localparam logic [7:0] ROUTE_OFF = 8'h80;
endpackage

// File: rtl/pirq_link_tbl.sv
module pirq_link_tbl #(
  parameter int N_LINK = 8,
  parameter int N_IRQ  = 16,
  parameter int CNT_W  = 8,
  localparam int LINK_IW = $clog2(N_LINK),
  localparam int IRQ_W   = $clog2(N_IRQ)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inc_en,
  input  logic [LINK_IW-1:0]             inc_idx,
  input  logic                           set_en,
  input  logic [LINK_IW-1:0]             set_idx,
  input  logic [IRQ_W-1:0]               set_irq,
  output logic [N_LINK-1:0][CNT_W-1:0]   use_cnt,
  output logic [N_LINK-1:0]              unrouted
);
  import pirq_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < N_LINK; g++) begin : g_link
    logic [7:0] route_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        use_cnt[g] <= '0;
        route_q    <= ROUTE_OFF;
      end else begin
        if (inc_en && inc_idx == LINK_IW'(g) && use_cnt[g] != CNT_MAX)
          use_cnt[g] <= use_cnt[g] + 1'b1;
        if (set_en && set_idx == LINK_IW'(g))
          route_q <= 8'(set_irq);
      end
    end
    assign unrouted[g] = (route_q == ROUTE_OFF);
  end
endmodule

// File: rtl/pirq_irq_tbl.sv
module pirq_irq_tbl #(
  parameter int              N_IRQ    = 16,
  parameter int              CNT_W    = 8,
  parameter logic [N_IRQ-1:0] IRQ_MASK = 16'hDEF8,
  localparam int IRQ_W = $clog2(N_IRQ)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic                          cmd_op,
  input  logic [IRQ_W-1:0]              cmd_irq,
  input  logic                          alloc_accept,
  input  logic                          inc_en,
  input  logic [IRQ_W-1:0]              inc_idx,
  output logic [N_IRQ-1:0][CNT_W-1:0]   irq_cnt,
  output logic                          cmd_err
);
  import pirq_pkg::*;
  localparam logic [CNT_W-1:0] SENT   = '1;
  localparam logic [CNT_W-1:0] CNT_TOP = SENT - 1'b1;

  logic open_q;
  logic cmd_ok;

  assign cmd_ok = cmd_valid && open_q && !alloc_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b1;
      cmd_err <= 1'b0;
    end else begin
      if (alloc_accept) open_q <= 1'b0;
      if (cmd_valid && !cmd_ok) cmd_err <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    localparam logic [CNT_W-1:0] RST_VAL = IRQ_MASK[g] ? '0 : SENT;
    logic hit_cmd, hit_inc;
    assign hit_cmd = cmd_ok && cmd_irq == IRQ_W'(g);
    assign hit_inc = inc_en && inc_idx == IRQ_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_cnt[g] <= RST_VAL;
      end else if (hit_cmd && cmd_op == OP_RESERVE) begin
        irq_cnt[g] <= SENT;
      end else if ((hit_cmd || hit_inc) && irq_cnt[g] < CNT_TOP) begin
        irq_cnt[g] <= irq_cnt[g] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl #(
  parameter int N_LINK   = 8,
  parameter int N_IRQ    = 16,
  parameter int CNT_W    = 8,
  parameter int SLOT_W   = 5,
  parameter int FIX_BASE = 4,
  localparam int LINK_IW = $clog2(N_LINK),
  localparam int IRQ_W   = $clog2(N_IRQ),
  localparam int NUM_W   = $clog2(N_LINK + 1),
  localparam int SUM_W   = SLOT_W + 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          alloc_valid,
  input  logic [SLOT_W-1:0]             slot,
  input  logic [1:0]                    intpin,
  input  logic                          fixed_mode,
  input  logic [N_LINK-1:0][CNT_W-1:0]  link_cnt,
  input  logic [N_LINK-1:0]             link_unrouted,
  input  logic [N_IRQ-1:0][CNT_W-1:0]   irq_cnt,
  output logic                          alloc_ready,
  output logic                          alloc_accept,
  output logic                          busy,
  output logic                          link_inc_en,
  output logic [LINK_IW-1:0]            link_inc_idx,
  output logic                          irq_inc_en,
  output logic [IRQ_W-1:0]              irq_inc_idx,
  output logic [LINK_IW-1:0]            sel_link,
  output logic                          done,
  output logic [NUM_W-1:0]              link_num,
  output logic                          route_we,
  output logic [IRQ_W-1:0]              route_irq
);
  import pirq_pkg::*;
  localparam logic [CNT_W-1:0] SENT = '1;

  alloc_st_e           state;
  logic [LINK_IW-1:0]  l_idx, l_best, fix_idx, l_win;
  logic [CNT_W-1:0]    l_best_cnt, l_cand;
  logic                fixed_q, l_take, l_last;
  logic [IRQ_W-1:0]    i_idx, i_best, i_win;
  logic [CNT_W-1:0]    i_best_cnt, i_cand;
  logic                i_found, i_take, i_last, i_any;
  logic [SUM_W-1:0]    fix_sum;

  assign fix_sum = SUM_W'(FIX_BASE) + SUM_W'(slot) + SUM_W'(intpin) + SUM_W'(1);

  assign l_cand = link_cnt[l_idx];
  assign l_take = (l_idx == '0) || (l_cand < l_best_cnt);
  assign l_last = (l_idx == LINK_IW'(N_LINK - 1));
  assign l_win  = fixed_q ? fix_idx : (l_take ? l_idx : l_best);

  assign i_cand = irq_cnt[i_idx];
  assign i_take = (i_cand != SENT) && (!i_found || i_cand < i_best_cnt);
  assign i_last = (i_idx == IRQ_W'(N_IRQ - 1));
  assign i_win  = i_take ? i_idx : i_best;
  assign i_any  = i_take || i_found;

  assign alloc_ready  = (state == ST_IDLE);
  assign busy         = !alloc_ready;
  assign alloc_accept = alloc_valid && alloc_ready;

  assign link_inc_en  = (state == ST_LINK) && l_last;
  assign link_inc_idx = l_win;
  assign irq_inc_en   = (state == ST_IRQ) && i_last && i_any;
  assign irq_inc_idx  = i_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      l_idx      <= '0;
      l_best     <= '0;
      l_best_cnt <= '0;
      fix_idx    <= '0;
      fixed_q    <= 1'b0;
      sel_link   <= '0;
      i_idx      <= '0;
      i_best     <= '0;
      i_best_cnt <= '0;
      i_found    <= 1'b0;
      done       <= 1'b0;
      link_num   <= '0;
      route_we   <= 1'b0;
      route_irq  <= '0;
    end else begin
      done     <= 1'b0;
      route_we <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (alloc_valid) begin
            state   <= ST_LINK;
            l_idx   <= '0;
            fixed_q <= fixed_mode;
            fix_idx <= fix_sum[LINK_IW-1:0];
          end
        end
        ST_LINK: begin
          if (!l_last) begin
            l_idx <= l_idx + 1'b1;
            if (l_take) begin
              l_best     <= l_idx;
              l_best_cnt <= l_cand;
            end
          end else begin
            sel_link <= l_win;
            link_num <= NUM_W'(l_win) + NUM_W'(1);
            if (link_unrouted[l_win]) begin
              state   <= ST_IRQ;
              i_idx   <= '0;
              i_found <= 1'b0;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_IRQ: begin
          if (!i_last) begin
            i_idx <= i_idx + 1'b1;
            if (i_take) begin
              i_best     <= i_idx;
              i_best_cnt <= i_cand;
              i_found    <= 1'b1;
            end
          end else begin
            state <= ST_IDLE;
            done  <= 1'b1;
            if (i_any) begin
              route_we  <= 1'b1;
              route_irq <= i_win;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pirq_allocator.sv
module pirq_allocator #(
  parameter int               N_LINK   = 8,
  parameter int               N_IRQ    = 16,
  parameter int               CNT_W    = 8,
  parameter int               SLOT_W   = 5,
  parameter int               FIX_BASE = 4,
  parameter logic [N_IRQ-1:0] IRQ_MASK = 16'hDEF8,
  localparam int LINK_IW = $clog2(N_LINK),
  localparam int IRQ_W   = $clog2(N_IRQ),
  localparam int NUM_W   = $clog2(N_LINK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [SLOT_W-1:0] slot,
  input  logic [1:0]        intpin,
  input  logic              fixed_mode,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [IRQ_W-1:0]  cmd_irq,
  output logic              busy,
  output logic              done,
  output logic [NUM_W-1:0]  link_num,
  output logic              route_we,
  output logic [NUM_W-1:0]  route_link,
  output logic [IRQ_W-1:0]  route_irq,
  output logic              cmd_err
);
  logic [N_LINK-1:0][CNT_W-1:0] link_cnt;
  logic [N_LINK-1:0]            link_unrouted;
  logic [N_IRQ-1:0][CNT_W-1:0]  irq_cnt;
  logic                         alloc_accept;
  logic                         link_inc_en, irq_inc_en;
  logic [LINK_IW-1:0]           link_inc_idx, sel_link;
  logic [IRQ_W-1:0]             irq_inc_idx;

  assign route_link = link_num;

  pirq_ctrl #(
    .N_LINK(N_LINK), .N_IRQ(N_IRQ), .CNT_W(CNT_W),
    .SLOT_W(SLOT_W), .FIX_BASE(FIX_BASE)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .slot         (slot),
    .intpin       (intpin),
    .fixed_mode   (fixed_mode),
    .link_cnt     (link_cnt),
    .link_unrouted(link_unrouted),
    .irq_cnt      (irq_cnt),
    .alloc_ready  (alloc_ready),
    .alloc_accept (alloc_accept),
    .busy         (busy),
    .link_inc_en  (link_inc_en),
    .link_inc_idx (link_inc_idx),
    .irq_inc_en   (irq_inc_en),
    .irq_inc_idx  (irq_inc_idx),
    .sel_link     (sel_link),
    .done         (done),
    .link_num     (link_num),
    .route_we     (route_we),
    .route_irq    (route_irq)
  );

  pirq_link_tbl #(
    .N_LINK(N_LINK), .N_IRQ(N_IRQ), .CNT_W(CNT_W)
  ) u_links (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (link_inc_en),
    .inc_idx (link_inc_idx),
    .set_en  (irq_inc_en),
    .set_idx (sel_link),
    .set_irq (irq_inc_idx),
    .use_cnt (link_cnt),
    .unrouted(link_unrouted)
  );

  pirq_irq_tbl #(
    .N_IRQ(N_IRQ), .CNT_W(CNT_W), .IRQ_MASK(IRQ_MASK)
  ) u_irqs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_irq     (cmd_irq),
    .alloc_accept(alloc_accept),
    .inc_en      (irq_inc_en),
    .inc_idx     (irq_inc_idx),
    .irq_cnt     (irq_cnt),
    .cmd_err     (cmd_err)
  );
endmodule

// File: rtl/pirq_alloc_chk.sv
module pirq_alloc_chk #(
  parameter int               N_LINK   = 8,
  parameter int               N_IRQ    = 16,
  parameter logic [N_IRQ-1:0] IRQ_MASK = 16'hDEF8,
  localparam int IRQ_W = $clog2(N_IRQ),
  localparam int NUM_W = $clog2(N_LINK + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             busy,
  input logic             done,
  input logic [NUM_W-1:0] link_num,
  input logic             route_we,
  input logic [NUM_W-1:0] route_link,
  input logic [IRQ_W-1:0] route_irq,
  input logic             cmd_err
);
  a_r2_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> busy);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  a_r6_link_range: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (link_num >= NUM_W'(1) && link_num <= NUM_W'(N_LINK)));

  a_r7_write_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    route_we |-> (done && route_link == link_num));

  a_r8_allowed_line: assert property (@(posedge clk) disable iff (!rst_n)
    route_we |-> IRQ_MASK[route_irq]);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
endmodule

bind pirq_allocator pirq_alloc_chk #(
  .N_LINK(N_LINK), .N_IRQ(N_IRQ), .IRQ_MASK(IRQ_MASK)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready),
  .busy       (busy),
  .done       (done),
  .link_num   (link_num),
  .route_we   (route_we),
  .route_link (route_link),
  .route_irq  (route_irq),
  .cmd_err    (cmd_err)
);

// File: tb/sim_pirq_allocator.sv
module sim_pirq_allocator;
  localparam int PERIOD = 10;
  localparam logic [15:0] MASK = 16'hDEF8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       alloc_valid = 1'b0;
  logic       alloc_ready;
  logic [4:0] slot = '0;
  logic [1:0] intpin = '0;
  logic       fixed_mode = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_op = 1'b0;
  logic [3:0] cmd_irq = '0;
  logic       busy, done, route_we, cmd_err;
  logic [3:0] link_num, route_link, route_irq;

  int n_chk = 0;
  int n_err = 0;

  int m_use [8];
  int m_route [8];
  int m_cnt [16];
  bit m_open;
  bit m_err;

  always #(PERIOD/2) clk = ~clk;

  pirq_allocator u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .slot(slot), .intpin(intpin), .fixed_mode(fixed_mode),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_irq(cmd_irq),
    .busy(busy), .done(done), .link_num(link_num), .route_we(route_we),
    .route_link(route_link), .route_irq(route_irq), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pick_link(input bit fx, input int s, input int p);
    int best = 0;
    if (fx) return (4 + s + p + 1) % 8;
    for (int i = 1; i < 8; i++) if (m_use[i] < m_use[best]) best = i;
    return best;
  endfunction

  function automatic int pick_irq();
    int best = -1;
    for (int i = 0; i < 16; i++)
      if (m_cnt[i] != 255 && (best < 0 || m_cnt[i] < m_cnt[best])) best = i;
    return best;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 8; i++) begin m_use[i] = 0; m_route[i] = -1; end
    for (int i = 0; i < 16; i++) m_cnt[i] = MASK[i] ? 0 : 255;
    m_open = 1'b1;
    m_err = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(alloc_ready && !busy && !done && !route_we && !cmd_err, "R1 reset outputs",
        {alloc_ready, busy, done, route_we, cmd_err}, 5'b10000);
  endtask

  task automatic do_cmd(input bit op, input int irq);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_irq = 4'(irq);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (m_open) begin
      if (op == 1'b0) m_cnt[irq] = 255;
      else if (m_cnt[irq] < 254) m_cnt[irq]++;
    end else begin
      m_err = 1'b1;
    end
    chk(cmd_err == m_err, "R11 cmd_err after command", cmd_err, m_err);
  endtask

  task automatic do_alloc(input bit fx, input int s, input int p, input bit hold);
    int lk, iq, lat, n;
    bit got;
    @(negedge clk);
    alloc_valid = 1'b1; fixed_mode = fx; slot = 5'(s); intpin = 2'(p);
    chk(alloc_ready == 1'b1, "R2 ready before request", alloc_ready, 1);
    @(posedge clk); #1;
    m_open = 1'b0;
    lk = pick_link(fx, s, p);
    iq = -1;
    lat = 8;
    if (m_route[lk] < 0) begin
      lat = 24;
      iq = pick_irq();
      if (iq >= 0) begin m_route[lk] = iq; m_cnt[iq]++; end
    end
    m_use[lk]++;
    if (!hold) alloc_valid = 1'b0;
    n = 0; got = 1'b0;
    while (!got && n < 40) begin
      @(posedge clk); #1;
      n++;
      if (n == 1) chk(busy && !alloc_ready, "R2 busy after accept", busy, 1);
      if (n == 3) alloc_valid = 1'b0;
      if (done) got = 1'b1;
    end
    alloc_valid = 1'b0;
    chk(n == lat, "R3 done latency", n, lat);
    chk(int'(link_num) == lk + 1, fx ? "R5 fixed link" : "R4 R6 least-used link",
        link_num, lk + 1);
    chk(route_we == (iq >= 0), iq < 0 && lat == 24 ? "R12 no write" : "R7 route write",
        route_we, iq >= 0);
    if (iq >= 0) begin
      chk(int'(route_irq) == iq && route_link == link_num, "R7 routed line",
          route_irq, iq);
      chk(MASK[route_irq], "R8 line allowed", route_irq, iq);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd7411);

    // R12: every line reserved, searches find nothing
    do_reset();
    for (int i = 0; i < 16; i++) do_cmd(1'b0, i);
    chk(cmd_err == 1'b0, "R11 no error before lockout", cmd_err, 0);
    do_alloc(1'b0, 0, 0, 1'b0);
    do_alloc(1'b0, 1, 0, 1'b0);
    do_alloc(1'b1, 3, 0, 1'b0);   // (4+3+1)%8 = link 0 again, still unrouted: R12
    do_cmd(1'b1, 5);               // R11: late command flagged

    // R9 R10: reserve line 3, pre-load 4 and 5, use on reserved 3 ignored
    do_reset();
    do_cmd(1'b0, 3);
    do_cmd(1'b1, 4);
    do_cmd(1'b1, 4);
    do_cmd(1'b1, 5);
    do_cmd(1'b1, 3);
    do_cmd(1'b1, 0);
    do_alloc(1'b0, 2, 1, 1'b1);   // picks line 6 (R9 R10), request held while busy (R2)
    do_cmd(1'b0, 7);               // R11: ignored, line 7 still next
    do_alloc(1'b0, 2, 2, 1'b0);   // link 2 -> line 7
    for (int i = 0; i < 60; i++) begin
      bit fx;
      fx = ($urandom % 3) == 0;
      if (($urandom % 6) == 0) do_cmd(1'($urandom), $urandom % 16);
      do_alloc(fx, $urandom % 32, $urandom % 4, 1'($urandom));
    end

    // R4 tie breaking after fixed-mode skew
    do_reset();
    do_alloc(1'b1, 0, 3, 1'b0);   // (4+0+4)%8 = link 0
    do_alloc(1'b1, 2, 1, 1'b0);   // link 0 again
    do_alloc(1'b0, 0, 0, 1'b0);   // least-used tie -> link 1
    do_alloc(1'b0, 0, 0, 1'b0);   // link 2
    for (int i = 0; i < 12; i++) do_alloc(1'b0, i, i % 4, 1'b0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule